// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between a processor's instruction fetch port and a word-wide instruction memory. It holds 256 lines of four 32-bit words each and answers a fetch in the same cycle when the addressed word is present. A fetch that misses goes to memory one word at a time. The requested word is handed to the fetch port in the cycle that memory returns it.

A miss does not load the whole line. It loads only the words from the requested word to the last word of the line. Each line records the start word of its fill together with its address tag. A later fetch of an earlier word in that line therefore misses and refills the line from the lower start.

Addresses at or above 0xA000_0000 bypass the cache: each such fetch makes a single memory read and never takes a line. A memory error on the requested word is reported as an instruction bus error, and the word returned is all zeros. The cache does not observe memory writes, so code that is rewritten in memory keeps hitting on the old words until the line is replaced or invalidated.

Top module: `ifetch_cache`

## Requirements
- R1: Line index is fetch address bits [11:4] and word select is bits [3:2]. A hit raises fe_ready in the same cycle as fe_valid, returns the stored word and issues no memory read.
- R2: A fetch hits only when all three hold: the line is valid, fetch address bits [31:4] equal the stored address bits [31:4], and fetch bits [3:2] are not below the stored start word.
- R3: Fetches at or above 0xA000_0000 make exactly one memory read each, never allocate a line and miss again on repetition. Addresses just below that bound are cached.
- R4: A cached miss reads words start..3 of the line in ascending order, one read per handshake. It writes only those words and records the fetch address (line plus start word) as the new tag.
- R5: On a miss, fe_ready stays low until memory acknowledges the requested word. In that ack cycle fe_ready is high and fe_rdata carries the memory word.
- R6: If memory flags an error on the requested word, fe_berr is high, fe_rdata is zero and no line is allocated, so the same fetch goes to memory again.
- R7: Memory changes are not observed: a hit returns the word captured at fill time.
- R8: Reset and a one-cycle flush_all pulse clear every line's valid bit. After either, every fetch misses.
- R9: mem_req stays high with a stable, word-aligned mem_addr until mem_ack.
- R10: A cached miss to a line index that holds a different address replaces that line, and the replaced address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Invalidate every line |
| fe_valid | input | 1 | Fetch request valid |
| fe_addr | input | 32 | Fetch byte address |
| fe_ready | output | 1 | Fetch accepted, response valid this cycle |
| fe_rdata | output | 32 | Instruction word |
| fe_berr | output | 1 | Instruction bus error for this fetch |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Word-aligned memory read address |
| mem_ack | input | 1 | Read completed, one cycle |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Read address invalid, sampled with mem_ack |

## Verification
The checker assumes that fe_valid and fe_addr stay stable from request until fe_ready, and that mem_ack is a single-cycle pulse answering a pending mem_req, with mem_rdata and mem_err valid in that cycle. It also assumes flush_all is pulsed only while no miss is being served. The stimulus drops fe_valid right after each handshake and waits for the refill to finish before the next fetch or flush. Its memory model answers each request after a fixed delay with a one-cycle acknowledge. Memory contents are a function of address and a generation count, and a fixed address window returns errors, so stale data and error paths can be predicted independently.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_BYPASS = 2'd2
  } ifc_state_e;

  localparam int unsigned BYTE_OFF_W = 2;
endpackage

// File: rtl/ifc_tag_store.sv
module ifc_tag_store #(
  parameter int unsigned LINES  = 256,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned TAG_W  = 20,
  parameter int unsigned WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              clr_en,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [WSEL_W-1:0] wr_start,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [WSEL_W-1:0] rd_start
);
  localparam int unsigned ENT_W = TAG_W + WSEL_W;

  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] vld_d;
  logic             vld_en;
  logic [ENT_W-1:0] tag_q [LINES];

  // next state of the valid vector
  always_comb begin
    vld_d  = vld_q;
    vld_en = inv_all | clr_en | set_en;
    if (inv_all) begin
      vld_d = '0;
    end else if (clr_en || set_en) begin
      vld_d[wr_idx] = set_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (vld_en) begin
      vld_q <= vld_d;
    end
  end

  // tag entries carry no reset; valid bits guard them
  always_ff @(posedge clk) begin
    if (set_en) begin
      tag_q[wr_idx] <= {wr_tag, wr_start};
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx][ENT_W-1:WSEL_W];
  assign rd_start = tag_q[rd_idx][WSEL_W-1:0];
endmodule

// File: rtl/ifc_data_store.sv
module ifc_data_store #(
  parameter int unsigned LINES  = 256,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned WSEL_W = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] bank_rd [WORDS];

  // one bank per word position of a line
  for (genvar w = 0; w < WORDS; w++) begin : g_bank
    logic [DATA_W-1:0] bank_q [LINES];
    logic              bank_we;

    assign bank_we = we && (wr_word == WSEL_W'(w));

    always_ff @(posedge clk) begin
      if (bank_we) begin
        bank_q[wr_idx] <= wr_data;
      end
    end

    assign bank_rd[w] = bank_q[rd_idx];
  end

  assign rd_data = bank_rd[rd_word];
endmodule

// File: rtl/ifc_refill_ctrl.sv
module ifc_refill_ctrl
  import ifc_pkg::*;
#(
  parameter int unsigned LINE_W = 28,
  parameter int unsigned WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  input  logic [WSEL_W-1:0] req_word,
  input  logic              req_hit,
  input  logic              req_uncached,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              ctrl_idle,
  output logic              mem_req,
  output logic [LINE_W-1:0] cur_line,
  output logic [WSEL_W-1:0] cur_word,
  output logic [WSEL_W-1:0] start_word,
  output logic              resp_valid,
  output logic              fill_active,
  output logic              dat_we,
  output logic              line_clr,
  output logic              line_set
);
  localparam logic [WSEL_W-1:0] LAST_WORD = '1;

  ifc_state_e        state_q, state_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [WSEL_W-1:0] word_q, word_d;
  logic [WSEL_W-1:0] start_q, start_d;
  logic              first_q, first_d;
  logic              upd_en;
  logic              fill_ok;
  logic              at_last;

  assign at_last = (word_q == LAST_WORD);

  always_comb begin
    state_d = state_q;
    line_d  = line_q;
    word_d  = word_q;
    start_d = start_q;
    first_d = first_q;
    upd_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && !req_hit) begin
          upd_en  = 1'b1;
          line_d  = req_line;
          word_d  = req_word;
          start_d = req_word;
          first_d = 1'b1;
          state_d = req_uncached ? ST_BYPASS : ST_FILL;
        end
      end
      ST_BYPASS: begin
        if (mem_ack) begin
          upd_en  = 1'b1;
          first_d = 1'b0;
          state_d = ST_IDLE;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          upd_en  = 1'b1;
          first_d = 1'b0;
          if (mem_err || at_last) begin
            state_d = ST_IDLE;
          end else begin
            word_d = word_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (upd_en) begin
        first_q <= first_d;
      end
    end
  end

  // datapath registers: loaded under enable, no reset
  always_ff @(posedge clk) begin
    if (upd_en) begin
      line_q  <= line_d;
      word_q  <= word_d;
      start_q <= start_d;
    end
  end

  assign ctrl_idle   = (state_q == ST_IDLE);
  assign fill_active = (state_q == ST_FILL);
  assign mem_req     = !ctrl_idle;
  assign cur_line    = line_q;
  assign cur_word    = word_q;
  assign start_word  = start_q;
  assign resp_valid  = mem_req && mem_ack && first_q;
  assign fill_ok     = fill_active && mem_ack && !mem_err;
  assign dat_we      = fill_ok;
  // the line stops hitting once its first new word lands, and is
  // committed with its new tag only when the last word lands
  assign line_clr    = fill_ok && first_q && !at_last;
  assign line_set    = fill_ok && at_last;
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache #(
  parameter int unsigned       ADDR_W        = 32,
  parameter int unsigned       DATA_W        = 32,
  parameter int unsigned       LINES         = 256,
  parameter int unsigned       WORDS         = 4,
  parameter logic [ADDR_W-1:0] UNCACHED_BASE = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              fe_valid,
  input  logic [ADDR_W-1:0] fe_addr,
  output logic              fe_ready,
  output logic [DATA_W-1:0] fe_rdata,
  output logic              fe_berr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_err
);
  import ifc_pkg::*;

  localparam int unsigned IDX_W    = $clog2(LINES);
  localparam int unsigned WSEL_W   = $clog2(WORDS);
  localparam int unsigned LINE_LSB = WSEL_W + BYTE_OFF_W;
  localparam int unsigned LINE_W   = ADDR_W - LINE_LSB;
  localparam int unsigned TAG_W    = LINE_W - IDX_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rsync_q[1];

  // address split
  logic [LINE_W-1:0] req_line;
  logic [WSEL_W-1:0] req_word;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              req_uncached;
  logic              byte_off_unused;

  assign req_line        = fe_addr[ADDR_W-1:LINE_LSB];
  assign req_word        = fe_addr[BYTE_OFF_W +: WSEL_W];
  assign req_idx         = req_line[IDX_W-1:0];
  assign req_tag         = req_line[LINE_W-1:IDX_W];
  assign req_uncached    = (fe_addr >= UNCACHED_BASE);
  assign byte_off_unused = ^fe_addr[BYTE_OFF_W-1:0];

  // lookup
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [WSEL_W-1:0] rd_start;
  logic [DATA_W-1:0] hit_data;
  logic              lookup_hit;

  assign lookup_hit = rd_valid && !req_uncached &&
                      (rd_tag == req_tag) && (req_word >= rd_start);

  // refill control
  logic              ctrl_idle;
  logic [LINE_W-1:0] cur_line;
  logic [WSEL_W-1:0] cur_word;
  logic [WSEL_W-1:0] start_word;
  logic              resp_valid;
  logic              fill_active;
  logic              dat_we;
  logic              line_clr;
  logic              line_set;

  ifc_refill_ctrl #(
    .LINE_W (LINE_W),
    .WSEL_W (WSEL_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .req_valid    (fe_valid),
    .req_line     (req_line),
    .req_word     (req_word),
    .req_hit      (lookup_hit),
    .req_uncached (req_uncached),
    .mem_ack      (mem_ack),
    .mem_err      (mem_err),
    .ctrl_idle    (ctrl_idle),
    .mem_req      (mem_req),
    .cur_line     (cur_line),
    .cur_word     (cur_word),
    .start_word   (start_word),
    .resp_valid   (resp_valid),
    .fill_active  (fill_active),
    .dat_we       (dat_we),
    .line_clr     (line_clr),
    .line_set     (line_set)
  );

  ifc_tag_store #(
    .LINES  (LINES),
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W),
    .WSEL_W (WSEL_W)
  ) u_tags (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .inv_all  (flush_all),
    .clr_en   (line_clr),
    .set_en   (line_set),
    .wr_idx   (cur_line[IDX_W-1:0]),
    .wr_tag   (cur_line[LINE_W-1:IDX_W]),
    .wr_start (start_word),
    .rd_idx   (req_idx),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_start (rd_start)
  );

  ifc_data_store #(
    .LINES  (LINES),
    .WORDS  (WORDS),
    .IDX_W  (IDX_W),
    .WSEL_W (WSEL_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk     (clk),
    .we      (dat_we),
    .wr_idx  (cur_line[IDX_W-1:0]),
    .wr_word (cur_word),
    .wr_data (mem_rdata),
    .rd_idx  (req_idx),
    .rd_word (req_word),
    .rd_data (hit_data)
  );

  // memory side
  assign mem_addr = {cur_line, cur_word, {BYTE_OFF_W{1'b0}}};

  // fetch response: a hit while idle, or the forwarded first word
  assign fe_ready = (ctrl_idle && fe_valid && lookup_hit) || resp_valid;
  assign fe_berr  = resp_valid && mem_err;
  always_comb begin
    if (resp_valid) begin
      fe_rdata = mem_err ? '0 : mem_rdata;
    end else begin
      fe_rdata = hit_data;
    end
  end
endmodule

// File: rtl/ifetch_cache_chk.sv
module ifetch_cache_chk #(
  parameter int unsigned       ADDR_W        = 32,
  parameter int unsigned       DATA_W        = 32,
  parameter int unsigned       WSEL_W        = 2,
  parameter logic [ADDR_W-1:0] UNCACHED_BASE = 32'hA000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_all,
  input logic              fe_valid,
  input logic              fe_ready,
  input logic [DATA_W-1:0] fe_rdata,
  input logic              fe_berr,
  input logic              lookup_hit,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              fill_active,
  input logic              line_set
);
  localparam logic [WSEL_W-1:0] LAST_WORD = '1;
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(4);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R9
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R6
  berr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_valid && fe_ready && fe_berr |-> fe_rdata == '0);

  // R5
  miss_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_valid && fe_ready && !lookup_hit |-> mem_req && mem_ack);

  // R4
  fill_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_active && mem_ack && !mem_err && (mem_addr[2 +: WSEL_W] != LAST_WORD)
    |=> fill_active && mem_req && (mem_addr == $past(mem_addr) + STEP));

  // R3
  uncached_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_set |-> mem_addr < UNCACHED_BASE);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lookup_hit);
endmodule

bind ifetch_cache ifetch_cache_chk #(
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .WSEL_W        (WSEL_W),
  .UNCACHED_BASE (UNCACHED_BASE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .flush_all   (flush_all),
  .fe_valid    (fe_valid),
  .fe_ready    (fe_ready),
  .fe_rdata    (fe_rdata),
  .fe_berr     (fe_berr),
  .lookup_hit  (lookup_hit),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_ack     (mem_ack),
  .mem_err     (mem_err),
  .fill_active (fill_active),
  .line_set    (line_set)
);

// File: tb/sim_ifetch_cache.sv
`timescale 1ns/1ps
module sim_ifetch_cache;
  logic        clk;
  logic        rst_n;
  logic        flush_all;
  logic        fe_valid;
  logic [31:0] fe_addr;
  logic        fe_ready;
  logic [31:0] fe_rdata;
  logic        fe_berr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        mem_err;

  int n_chk;
  int n_err;
  int gen;
  int rd_cnt;
  int dly;
  bit hs;

  typedef struct {
    logic [31:0] data;
    logic        berr;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  ifetch_cache u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_all (flush_all),
    .fe_valid  (fe_valid),
    .fe_addr   (fe_addr),
    .fe_ready  (fe_ready),
    .fe_rdata  (fe_rdata),
    .fe_berr   (fe_berr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .mem_err   (mem_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // memory image: function of word address and a generation count
  function automatic logic [31:0] memfn(input logic [31:0] a, input int g);
    return {a[31:2], 2'b00} ^ 32'hC3A5_0F1E ^ (32'(g) * 32'h0101_0101);
  endfunction

  // addresses whose bits [27:16] equal 0xF00 are invalid
  function automatic bit is_bad(input logic [31:0] a);
    return a[27:16] == 12'hF00;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: one-cycle ack after a fixed delay
  always @(posedge clk) begin
    #1;
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      if (dly >= 1) begin
        dly     = 0;
        mem_ack = 1'b1;
        rd_cnt++;
        mem_err   = is_bad(mem_addr);
        mem_rdata = mem_err ? 32'hDEAD_BEEF : memfn(mem_addr, gen);
      end else begin
        dly++;
      end
    end
  end

  // monitor: pops the scoreboard at every fetch handshake
  always @(negedge clk) begin
    if (rst_n && fe_valid && fe_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected response", fe_rdata, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(fe_rdata == e.data, e.req, "fe_rdata", fe_rdata, e.data);
        check(fe_berr == e.berr, e.req, "fe_berr", 32'(fe_berr), 32'(e.berr));
      end
      hs = 1'b1;
    end
  end

  // driver: one fetch, then the count of memory reads it caused
  task automatic fetch(input logic [31:0] a, input logic [31:0] ed, input bit eb,
                       input int ereads, input string req);
    int r0;
    exp_q.push_back('{data: ed, berr: eb, req: req});
    r0 = rd_cnt;
    @(posedge clk);
    #1;
    fe_addr  = a;
    fe_valid = 1'b1;
    hs       = 1'b0;
    while (!hs) @(posedge clk);
    #1;
    fe_valid = 1'b0;
    hs       = 1'b0;
    repeat (16) @(posedge clk);
    check(rd_cnt - r0 == ereads, req, "memory reads", 32'(rd_cnt - r0), 32'(ereads));
  endtask

  task automatic pulse_flush();
    @(posedge clk);
    #1 flush_all = 1'b1;
    @(posedge clk);
    #1 flush_all = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0; gen = 0; rd_cnt = 0; dly = 0; hs = 1'b0;
    rst_n = 1'b0; flush_all = 1'b0; fe_valid = 1'b0; fe_addr = '0;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R8: reset state, R9: no request pending
    check(mem_req == 1'b0, "R9", "mem_req after reset", 32'(mem_req), 32'h0);
    check(fe_berr == 1'b0, "R8", "fe_berr after reset", 32'(fe_berr), 32'h0);

    // R4 partial fill from word 2, R5 forwarding
    fetch(32'h0000_1008, memfn(32'h0000_1008, 0), 1'b0, 2, "R4");
    // R1 hit on a filled word
    fetch(32'h0000_100C, memfn(32'h0000_100C, 0), 1'b0, 0, "R1");
    // R2 word below stored start misses; full fill from word 0
    fetch(32'h0000_1000, memfn(32'h0000_1000, 0), 1'b0, 4, "R2");
    fetch(32'h0000_1004, memfn(32'h0000_1004, 0), 1'b0, 0, "R2");
    // R7 stale line after memory change
    gen = 1;
    fetch(32'h0000_1008, memfn(32'h0000_1008, 0), 1'b0, 0, "R7");
    // R10 conflicting line replaces, old address misses
    fetch(32'h0000_2008, memfn(32'h0000_2008, 1), 1'b0, 2, "R10");
    fetch(32'h0000_1008, memfn(32'h0000_1008, 1), 1'b0, 2, "R10");
    // R4 refill from word 1 reads three words
    fetch(32'h0000_1004, memfn(32'h0000_1004, 1), 1'b0, 3, "R4");
    fetch(32'h0000_1000, memfn(32'h0000_1000, 1), 1'b0, 4, "R4");
    // R3 uncached range, no allocation
    fetch(32'hA000_0010, memfn(32'hA000_0010, 1), 1'b0, 1, "R3");
    fetch(32'hA000_0010, memfn(32'hA000_0010, 1), 1'b0, 1, "R3");
    // R3 highest cached line
    fetch(32'h9FFF_FFF0, memfn(32'h9FFF_FFF0, 1), 1'b0, 4, "R3");
    fetch(32'h9FFF_FFF8, memfn(32'h9FFF_FFF8, 1), 1'b0, 0, "R3");
    // R6 bus error, zero word, no allocation
    fetch(32'h1F00_0104, 32'h0, 1'b1, 1, "R6");
    fetch(32'h1F00_0104, 32'h0, 1'b1, 1, "R6");
    fetch(32'hBF00_0000, 32'h0, 1'b1, 1, "R6");
    // R8 flush invalidates a valid line
    fetch(32'h0000_1004, memfn(32'h0000_1004, 1), 1'b0, 0, "R8");
    pulse_flush();
    fetch(32'h0000_1004, memfn(32'h0000_1004, 1), 1'b0, 3, "R8");
    // R4 fill of the last word only
    fetch(32'h0000_300C, memfn(32'h0000_300C, 1), 1'b0, 1, "R4");
    fetch(32'h0000_300C, memfn(32'h0000_300C, 1), 1'b0, 0, "R4");
    fetch(32'h0000_3008, memfn(32'h0000_3008, 1), 1'b0, 2, "R4");

    check(exp_q.size() == 0, "R5", "responses outstanding", 32'(exp_q.size()), 32'h0);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule